// File: doc/BRIEF.md
# Processor Interrupt Controller

This block sits beside a processor core and decides when the core leaves its program to service a device. Each device drives a request line into the controller. The controller latches requests into a pending register and masks them with a per-source enable register. At an instruction boundary it picks the highest-priority eligible source and checks that source against the global enable bit and the optional priority-level gate in the status register. When the source passes these checks, the controller tells the core to branch to a vector address and sends a one-cycle acknowledge to the chosen device.

When the controller takes an interrupt, it copies the status register into a saved-status register, clears the global enable and raises the current level to the level of the winning source. It also captures the return address that the core supplies. A return-from-interrupt strobe copies the saved status back into the status register. Software reads and writes the four control registers through a small select/data port.

Status word layout: bit 0 is the global enable (GIE), bit 1 turns the priority-level gate on (LGE), and bits [2 +: LVL_W] hold the current level. Source i has level `~i` in LVL_W bits, so index 0 has the highest level. Control select codes: 0 = status, 1 = saved status, 2 = source enable, 3 = pending (read-only).

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the status, saved-status, source-enable and pending registers read 0, `take_irq` is 0 and `dev_ack` is all zero.
- R2: Pending bit i is set on the clock edge at which `dev_req[i]` is sampled high. It stays set after the request drops and clears only on the edge at which `dev_ack[i]` is 1. It is read with select code 3.
- R3: A pending source whose source-enable bit is 0 is never taken or acknowledged.
- R4: `take_irq` rises only in a cycle with `insn_done`=1, `rti`=0 and GIE (status bit 0) = 1.
- R5: Among the enabled pending sources, the one with the lowest index wins. In the cycle of `take_irq`, `vec_addr` equals VEC_BASE + 4 × winner index.
- R6: `dev_ack` is one-hot at the winner in the same cycle as `take_irq` and is all zero in every other cycle.
- R7: On a take, the saved status receives the old status, GIE clears, LGE is kept, the level field becomes the winner's level `~index`, and `ret_pc` receives `next_pc`.
- R8: When LGE = 1, a take happens only if the winner's level is strictly greater than the current level. When LGE = 0, levels are ignored.
- R9: When `rti`=1, the status register is loaded from the saved status on that edge, and no interrupt is taken in that cycle.
- R10: Select code 0 writes status, 1 writes saved status and 2 writes source enable. A write to code 3 has no effect. A take or return in the same cycle wins over a status or saved-status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | N_SRC | Device request lines, held until acknowledged |
| dev_ack | output | N_SRC | One-cycle acknowledge to the chosen device |
| insn_done | input | 1 | Core strobe: an instruction completes this cycle |
| next_pc | input | ADDR_W | Address of the next instruction, captured on a take |
| rti | input | 1 | Core strobe: return-from-interrupt executes this cycle |
| take_irq | output | 1 | Core must branch to `vec_addr` |
| vec_addr | output | ADDR_W | Service routine address from the vector table |
| ret_pc | output | ADDR_W | Captured return address |
| ctl_we | input | 1 | Control register write strobe |
| ctl_sel | input | 2 | Control register select |
| ctl_wdata | input | DATA_W | Control register write data |
| ctl_rdata | output | DATA_W | Control register read data (combinational) |

## Verification
The main selection path runs against request patterns with a single source, several sources at once (to show that the lowest index wins), requests hidden by a partial enable mask (to separate masking from priority), and all sources with the global enable off. Level-gating patterns place the winner's level above, equal to and below the current level, and repeat with the gate off at a high level. Together these tell a strict comparison from a non-strict one and show whether the gate bit is honoured. Directed cases cover a return strobe in the same cycle as a boundary, a status write that collides with a take, a pending bit that outlives its request, and a second request arriving while the global enable is cleared.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared encodings for the interrupt controller.
// Assumes control selects are 2 bits and the status word is GIE, LGE, level.
package irq_ctrl_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_SAVED  = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_PEND   = 2'd3
    } ctl_sel_e;

    localparam int GIE_BIT = 0;
    localparam int LGE_BIT = 1;
    localparam int LVL_LSB = 2;

endpackage

// File: rtl/irq_pending.sv
// Module: pending request latch.
// Sets a bit whenever its request is sampled high and clears it only on an
// acknowledge. Assumes devices hold a request until they see the acknowledge.
module irq_pending #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] ack,
    output logic [N_SRC-1:0] pend
);

    // Accumulate requests; an acknowledge on the same edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend | req) & ~ack;
        end
    end

endmodule

// File: rtl/irq_mask.sv
// Module: per-source enable register and request masking.
// Holds the enable bits written by software and gates the pending vector.
// Assumes the write strobe is already decoded for this register.
module irq_mask #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N_SRC-1:0] wr_data,
    input  logic [N_SRC-1:0] pend,
    output logic [N_SRC-1:0] enable,
    output logic [N_SRC-1:0] eligible
);

    // Software-written enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (wr_en) begin
            enable <= wr_data;
        end
    end

    // Only enabled pending sources compete.
    always_comb begin
        eligible = pend & enable;
    end

endmodule

// File: rtl/irq_prio_enc.sv
// Module: fixed-priority selector, lowest index first.
// Produces a one-hot grant, the binary index of the winner and a valid flag.
// Assumes IDX_W is wide enough to hold N_SRC-1.
module irq_prio_enc #(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_SRC-1:0] req,
    output logic [N_SRC-1:0] grant,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);

    logic [N_SRC:0] lower_any;

    assign lower_any[0] = 1'b0;

    // One stage per source: grant if requesting and nothing lower requested.
    for (genvar i = 0; i < N_SRC; i++) begin : g_stage
        assign grant[i]       = req[i] & ~lower_any[i];
        assign lower_any[i+1] = lower_any[i] | req[i];
    end

    assign valid = lower_any[N_SRC];

    // Encode the one-hot grant into a binary index.
    always_comb begin
        idx = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (grant[k]) begin
                idx = idx | IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/irq_status.sv
// Module: status, saved-status and return-address registers.
// On a take: saves status, clears GIE, loads the winner level, captures the
// return address. On a return: restores status from the saved copy.
// Assumes take and rti are never high together (the top gates take).
module irq_status #(
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 32,
    localparam int PS_W  = LVL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [LVL_W-1:0]  win_lvl,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              rti,
    input  logic              wr_status,
    input  logic              wr_saved,
    input  logic [PS_W-1:0]   wr_data,
    output logic [PS_W-1:0]   status,
    output logic [PS_W-1:0]   saved,
    output logic [ADDR_W-1:0] ret_addr
);

    import irq_ctrl_pkg::*;

    logic [PS_W-1:0] entry_status;

    // Status value loaded on interrupt entry: GIE off, LGE kept, new level.
    always_comb begin
        entry_status                   = status;
        entry_status[GIE_BIT]          = 1'b0;
        entry_status[LVL_LSB +: LVL_W] = win_lvl;
    end

    // Status register: take, then return, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (take) begin
            status <= entry_status;
        end else if (rti) begin
            status <= saved;
        end else if (wr_status) begin
            status <= wr_data;
        end
    end

    // Saved-status register: filled on take, else by software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved <= '0;
        end else if (take) begin
            saved <= status;
        end else if (wr_saved && !rti) begin
            saved <= wr_data;
        end
    end

    // Return address captured at the interrupted boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_addr <= '0;
        end else if (take) begin
            ret_addr <= next_pc;
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
// Module: processor interrupt controller top.
// Latches and masks device requests, selects one by fixed priority, gates it
// with the global enable and the level comparison, and drives the take strobe,
// vector address and device acknowledge. Assumes N_SRC is a power of two no
// larger than DATA_W, and that VEC_BASE is word aligned.
module irq_ctrl #(
    parameter int                 N_SRC    = 8,
    parameter int                 ADDR_W   = 32,
    parameter int                 DATA_W   = 32,
    parameter logic [ADDR_W-1:0]  VEC_BASE = 32'h0000_0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  dev_req,
    output logic [N_SRC-1:0]  dev_ack,
    input  logic              insn_done,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              rti,
    output logic              take_irq,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [ADDR_W-1:0] ret_pc,
    input  logic              ctl_we,
    input  logic [1:0]        ctl_sel,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] ctl_rdata
);

    import irq_ctrl_pkg::*;

    localparam int LVL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int PS_W  = LVL_W + 2;

    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] ien_q;
    logic [N_SRC-1:0] eligible;
    logic [N_SRC-1:0] grant;
    logic [LVL_W-1:0] win_idx;
    logic             win_valid;
    logic [LVL_W-1:0] win_lvl;
    logic [LVL_W-1:0] cur_lvl;
    logic [PS_W-1:0]  ps_q;
    logic [PS_W-1:0]  ips_q;
    logic             level_ok;
    logic             wr_status;
    logic             wr_saved;
    logic             wr_enable;
    ctl_sel_e         sel;

    assign sel = ctl_sel_e'(ctl_sel);

    // Decode software writes; the pending register has no write path.
    always_comb begin
        wr_status = ctl_we && (sel == SEL_STATUS);
        wr_saved  = ctl_we && (sel == SEL_SAVED);
        wr_enable = ctl_we && (sel == SEL_ENABLE);
    end

    irq_pending #(.N_SRC(N_SRC)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (dev_req),
        .ack  (dev_ack),
        .pend (pend_q)
    );

    irq_mask #(.N_SRC(N_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_enable),
        .wr_data (ctl_wdata[N_SRC-1:0]),
        .pend    (pend_q),
        .enable  (ien_q),
        .eligible(eligible)
    );

    irq_prio_enc #(.N_SRC(N_SRC), .IDX_W(LVL_W)) u_enc (
        .req  (eligible),
        .grant(grant),
        .idx  (win_idx),
        .valid(win_valid)
    );

    irq_status #(.LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take_irq),
        .win_lvl  (win_lvl),
        .next_pc  (next_pc),
        .rti      (rti),
        .wr_status(wr_status),
        .wr_saved (wr_saved),
        .wr_data  (ctl_wdata[PS_W-1:0]),
        .status   (ps_q),
        .saved    (ips_q),
        .ret_addr (ret_pc)
    );

    // Level of the winner and the level gate against the current level.
    always_comb begin
        win_lvl  = ~win_idx;
        cur_lvl  = ps_q[LVL_LSB +: LVL_W];
        level_ok = !ps_q[LGE_BIT] || (win_lvl > cur_lvl);
    end

    // Recognition at an instruction boundary, never together with a return.
    always_comb begin
        take_irq = insn_done && !rti && ps_q[GIE_BIT] && win_valid && level_ok;
        dev_ack  = grant & {N_SRC{take_irq}};
        vec_addr = VEC_BASE + (ADDR_W'(win_idx) << 2);
    end

    // Control register read mux.
    always_comb begin
        unique case (sel)
            SEL_STATUS: ctl_rdata = DATA_W'(ps_q);
            SEL_SAVED:  ctl_rdata = DATA_W'(ips_q);
            SEL_ENABLE: ctl_rdata = DATA_W'(ien_q);
            SEL_PEND:   ctl_rdata = DATA_W'(pend_q);
        endcase
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
// Module: protocol checker for the interrupt controller, bound to the top.
// Observes strobes, acknowledges and the status registers.
module irq_ctrl_chk #(
    parameter int N_SRC = 8,
    parameter int PS_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             insn_done,
    input logic             rti,
    input logic             take_irq,
    input logic [N_SRC-1:0] dev_ack,
    input logic [N_SRC-1:0] ien,
    input logic [PS_W-1:0]  ps,
    input logic [PS_W-1:0]  ips
);

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (insn_done && !rti && ps[0])); // R4

    AST_ACK_ONEHOT_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> ($countones(dev_ack) == 1)); // R6

    AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take_irq |-> (dev_ack == '0)); // R6

    AST_ACK_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack & ~ien) == '0); // R3

    AST_ENTRY_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !ps[0]); // R7

    AST_ENTRY_SAVES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> (ips == $past(ps))); // R7

    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        rti |=> (ps == $past(ips))); // R9

endmodule

bind irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC), .PS_W(PS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .insn_done(insn_done),
    .rti      (rti),
    .take_irq (take_irq),
    .dev_ack  (dev_ack),
    .ien      (ien_q),
    .ps       (ps_q),
    .ips      (ips_q)
);

// File: tb/irq_ctrl_tb.sv
// Bench: table-driven selection cases, then directed corner cases.
module irq_ctrl_tb;

    localparam int          N      = 8;
    localparam logic [31:0] BASE   = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] dev_req = '0;
    logic [N-1:0] dev_ack;
    logic        insn_done = 1'b0;
    logic [31:0] next_pc = '0;
    logic        rti = 1'b0;
    logic        take_irq;
    logic [31:0] vec_addr;
    logic [31:0] ret_pc;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_sel = '0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_ctrl #(.N_SRC(N), .ADDR_W(32), .DATA_W(32), .VEC_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_ack(dev_ack),
        .insn_done(insn_done), .next_pc(next_pc), .rti(rti),
        .take_irq(take_irq), .vec_addr(vec_addr), .ret_pc(ret_pc),
        .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata)
    );

    // Vector fields: [24:17] enable, [16:9] requests, [8:4] status written,
    // [3] take expected, [2:0] winner index expected.
    localparam logic [24:0] VTAB [10] = '{
        {8'hFF, 8'h01, 5'b00001, 1'b1, 3'd0},
        {8'hFF, 8'hA4, 5'b00001, 1'b1, 3'd2},
        {8'hF0, 8'h8F, 5'b00001, 1'b1, 3'd7},
        {8'h00, 8'hFF, 5'b00001, 1'b0, 3'd0},
        {8'hFF, 8'hFF, 5'b00000, 1'b0, 3'd0},
        {8'hFF, 8'h20, 5'b00111, 1'b1, 3'd5},
        {8'hFF, 8'h20, 5'b01011, 1'b0, 3'd0},
        {8'hFF, 8'h60, 5'b01111, 1'b0, 3'd0},
        {8'hFF, 8'h80, 5'b11101, 1'b1, 3'd7},
        {8'h18, 8'h18, 5'b00001, 1'b1, 3'd3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        ctl_sel = sel;
        #1;
        val = ctl_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dev_req = '0; insn_done = 1'b0; rti = 1'b0; ctl_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        ctl_we = 1'b1; ctl_sel = sel; ctl_wdata = data;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  ack_exp;
        logic [4:0]  ps_exp;

        // R1: reset state
        do_reset();
        rd(2'd0, v); chk("R1 status", v, 32'h0);
        rd(2'd1, v); chk("R1 saved", v, 32'h0);
        rd(2'd2, v); chk("R1 enable", v, 32'h0);
        rd(2'd3, v); chk("R1 pending", v, 32'h0);
        chk("R1 take", {31'd0, take_irq}, 32'd0);
        chk("R1 ack", {24'd0, dev_ack}, 32'd0);

        // Table walk: R3 R5 R6 R7 R8
        for (int i = 0; i < 10; i++) begin
            logic [7:0] en, rq;
            logic [4:0] ps;
            logic       et;
            logic [2:0] ei;
            {en, rq, ps, et, ei} = VTAB[i];
            ack_exp = et ? (8'h01 << ei) : 8'h00;
            do_reset();
            wr(2'd2, {24'd0, en});
            @(negedge clk);
            ctl_we = 1'b1; ctl_sel = 2'd0; ctl_wdata = {27'd0, ps}; dev_req = rq;
            @(negedge clk);
            ctl_we = 1'b0;
            @(negedge clk);
            rd(2'd3, v); chk("R2 pending set", v, {24'd0, rq});
            next_pc = 32'h1000 + 32'(i) * 4;
            insn_done = 1'b1;
            #1;
            chk("R4 R8 take", {31'd0, take_irq}, {31'd0, et});
            chk("R3 R6 ack", {24'd0, dev_ack}, {24'd0, ack_exp});
            if (et) chk("R5 vector", vec_addr, BASE + 32'(ei) * 4);
            @(negedge clk);
            insn_done = 1'b0;
            dev_req = rq & ~ack_exp;
            ps_exp = et ? {~ei, ps[1], 1'b0} : ps;
            rd(2'd0, v); chk("R7 status after", v, {27'd0, ps_exp});
            rd(2'd1, v); chk("R7 saved after", v, et ? {27'd0, ps} : 32'd0);
            rd(2'd3, v); chk("R2 pending ack clear", v, {24'd0, rq & ~ack_exp});
            if (et) begin
                chk("R7 ret_pc", ret_pc, 32'h1000 + 32'(i) * 4);
                @(negedge clk);
                rti = 1'b1;
                @(negedge clk);
                rti = 1'b0;
                rd(2'd0, v); chk("R9 restore", v, {27'd0, ps});
            end
        end

        // R10: a write to the pending select is ignored
        do_reset();
        wr(2'd3, 32'hFF);
        rd(2'd3, v); chk("R10 pending write ignored", v, 32'h0);
        wr(2'd1, 32'h15);
        rd(2'd1, v); chk("R10 saved write", v, 32'h15);

        // R9 R4: return in the same cycle as a boundary takes nothing
        do_reset();
        wr(2'd2, 32'hFF);
        wr(2'd0, 32'h01);
        dev_req = 8'h01;
        @(negedge clk);
        @(negedge clk);
        insn_done = 1'b1; rti = 1'b1;
        #1;
        chk("R9 no take with rti", {31'd0, take_irq}, 32'd0);
        @(negedge clk);
        insn_done = 1'b0; rti = 1'b0;
        rd(2'd0, v); chk("R9 status from saved", v, 32'h0);

        // R10: a status write colliding with a take loses
        do_reset();
        wr(2'd2, 32'hFF);
        wr(2'd0, 32'h01);
        dev_req = 8'h02;
        @(negedge clk);
        @(negedge clk);
        insn_done = 1'b1; ctl_we = 1'b1; ctl_sel = 2'd0; ctl_wdata = 32'h01;
        #1;
        chk("R10 take during write", {31'd0, take_irq}, 32'd1);
        @(negedge clk);
        insn_done = 1'b0; ctl_we = 1'b0; dev_req = 8'h00;
        rd(2'd0, v); chk("R10 take wins status", v, 32'h18);
        rd(2'd1, v); chk("R10 saved on take", v, 32'h01);

        // R2: pending outlives a dropped request, then is taken
        do_reset();
        @(negedge clk);
        dev_req = 8'h04;
        @(negedge clk);
        dev_req = 8'h00;
        @(negedge clk);
        rd(2'd3, v); chk("R2 pending held", v, 32'h04);
        wr(2'd2, 32'h04);
        wr(2'd0, 32'h01);
        @(negedge clk);
        insn_done = 1'b1; next_pc = 32'h2000;
        #1;
        chk("R5 held request taken", {31'd0, take_irq}, 32'd1);
        chk("R5 held vector", vec_addr, BASE + 32'd8);
        @(negedge clk);
        insn_done = 1'b0;

        // R7 R4: with GIE cleared by entry, a new request waits
        wr(2'd2, 32'hFF);
        dev_req = 8'h01;
        @(negedge clk);
        @(negedge clk);
        insn_done = 1'b1;
        #1;
        chk("R4 GIE cleared blocks", {31'd0, take_irq}, 32'd0);
        chk("R6 no ack when blocked", {24'd0, dev_ack}, 32'd0);
        @(negedge clk);
        insn_done = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule